// File: doc/BRIEF.md
# Flash Operation Timing Sequencer

This block drives the timed erase and program sequences of an embedded flash array. Software loads three packed timing registers and an address register over a simple register bus. It then sets one command bit in the control register. The sequencer accepts the command, latches which operation won, and runs a fixed three-phase sequence:

- a setup phase,
- a main pulse,
- a hold phase.

Each phase length is a cycle count taken from a field of the timing registers. A busy flag in the status register and on a port stays high from command acceptance until the hold phase ends. A one-cycle done strobe then follows.

Towards the flash array the block presents a handshake:

- an active level covering all three phases;
- a pulse level covering only the main phase;
- an operation code;
- the target address.

The array model in the bench listens to this handshake.

The controller is a four-state machine with these states:

- ST_IDLE: waiting for a command.
- ST_SETUP: the setup interval.
- ST_MAIN: the erase or program pulse.
- ST_HOLD: the hold interval.

Its transitions are:

- start, taken from ST_IDLE to ST_SETUP when a command bit is pending;
- setup_end, from ST_SETUP to ST_MAIN;
- main_end, from ST_MAIN to ST_HOLD;
- hold_end, from ST_HOLD back to ST_IDLE, which also raises done.

Each of setup_end, main_end and hold_end is taken when the phase counter reaches its last cycle.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset every register reads zero, busy_o, done_o, fl_active and fl_pulse are low, and fl_op is 0.
- R2: Control bit 3 starts a mass erase (fl_op code 1), bit 4 a page erase (code 2), bit 5 a program (code 3), bit 6 a reference-cell erase (code 4) and bit 7 a trim recall (code 5). fl_op carries the code while fl_active is high and is 0 otherwise.
- R3: When several command bits are written together, the operation of the lowest-numbered set bit runs and the others are dropped.
- R4: The command bits self-clear when the operation starts, so the control register (offset 0x00, command bits [7:3]) reads zero from the second busy cycle on.
- R5: Status bit 0 (offset 0x14) and busy_o are high for exactly 1 + S + M + H cycles, counted from the cycle after the control write.
- R6: The phases run in the order setup (S cycles), main (M cycles), hold (H cycles). fl_pulse is high for exactly M cycles.
- R7: The timing field positions are as follows.
  - S comes from offset 0x0C bits [27:24].
  - H comes from offset 0x04 bits [31:16].
  - M depends on the operation:
    - for the three erase kinds, offset 0x08 bits [23:0];
    - for program, offset 0x0C bits [15:0];
    - for trim recall, offset 0x0C bits [23:16].
- R8: A timing count of zero runs that phase for one cycle.
- R9: While busy_o is high, every register write is ignored, including command writes, which therefore start no later operation.
- R10: fl_addr is the address register (offset 0x10) aligned down to a PAGE_BYTES page for a page erase. It is the address unchanged for a program, and zero for the other operations.
- R11: done_o is high for exactly one cycle, the first cycle in which busy_o is low after an operation.
- R12: rd_wait continuously shows offset 0x04 bits [5:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| busy_o | output | 1 | Operation pending or in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fl_active | output | 1 | Array handshake: operation phases running |
| fl_pulse | output | 1 | Array handshake: main pulse |
| fl_op | output | 3 | Array handshake: operation code |
| fl_addr | output | ADDR_W | Array handshake: target address |
| rd_wait | output | 6 | Read wait-state setting |

## Verification
The bench builds the block with its defaults: ADDR_W of 20, REG_AW of 6 and PAGE_BYTES of 4096. These widths let twenty-bit addresses exercise page alignment at the 4 KiB boundary, including an all-ones address. Timing values stay small, so each vector finishes within a few dozen cycles. This keeps in reach:

- every operation code;
- mixed command words that exercise the priority rule;
- zero counts in all three phases at once;
- writes landing while the sequence is running.

// File: rtl/fos_pkg.sv
package fos_pkg;

    localparam int DATA_W = 32;

    // register byte offsets
    localparam logic [5:0] OFS_CTRL  = 6'h00;
    localparam logic [5:0] OFS_TIM_A = 6'h04;
    localparam logic [5:0] OFS_TIM_B = 6'h08;
    localparam logic [5:0] OFS_TIM_C = 6'h0C;
    localparam logic [5:0] OFS_ADDR  = 6'h10;
    localparam logic [5:0] OFS_STAT  = 6'h14;

    // field geometry
    localparam int CMD_LO    = 3;
    localparam int CMD_N     = 5;
    localparam int WAIT_W    = 6;
    localparam int HOLD_LO   = 16;
    localparam int HOLD_W    = 16;
    localparam int ERASE_W   = 24;
    localparam int PROG_W    = 16;
    localparam int RECALL_LO = 16;
    localparam int RECALL_W  = 8;
    localparam int SETUP_LO  = 24;
    localparam int SETUP_W   = 4;
    localparam int CNT_W     = ERASE_W;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_MASS   = 3'd1,
        OP_PAGE   = 3'd2,
        OP_PROG   = 3'd3,
        OP_REF    = 3'd4,
        OP_RECALL = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_MAIN,
        ST_HOLD
    } state_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [HOLD_W-1:0]   hold;
        logic [ERASE_W-1:0]  erase;
        logic [PROG_W-1:0]   prog;
        logic [RECALL_W-1:0] recall;
        logic [WAIT_W-1:0]   wait_st;
    } timing_t;

endpackage

// File: rtl/fos_regfile.sv
module fos_regfile
    import fos_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int REG_AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                busy_i,
    input  logic                start_i,
    output logic [CMD_N-1:0]    cmd_o,
    output timing_t             tim_o,
    output logic [ADDR_W-1:0]   flash_addr_o,
    output logic [DATA_W-1:0]   rdata_o
);

    logic [CMD_N-1:0]  cmd_q;
    logic [DATA_W-1:0] tim_a_q, tim_b_q, tim_c_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_ok;

    assign wr_ok = wr_i && !busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            tim_a_q <= '0;
            tim_b_q <= '0;
            tim_c_q <= '0;
            addr_q  <= '0;
        end else begin
            if (start_i) begin
                cmd_q <= '0;
            end else if (wr_ok && addr_i == REG_AW'(OFS_CTRL)) begin
                cmd_q <= wdata_i[CMD_LO +: CMD_N];
            end
            if (wr_ok && addr_i == REG_AW'(OFS_TIM_A)) tim_a_q <= wdata_i;
            if (wr_ok && addr_i == REG_AW'(OFS_TIM_B)) tim_b_q <= wdata_i;
            if (wr_ok && addr_i == REG_AW'(OFS_TIM_C)) tim_c_q <= wdata_i;
            if (wr_ok && addr_i == REG_AW'(OFS_ADDR))  addr_q  <= wdata_i[ADDR_W-1:0];
        end
    end

    always_comb begin
        tim_o.wait_st = tim_a_q[WAIT_W-1:0];
        tim_o.hold    = tim_a_q[HOLD_LO +: HOLD_W];
        tim_o.erase   = tim_b_q[ERASE_W-1:0];
        tim_o.prog    = tim_c_q[PROG_W-1:0];
        tim_o.recall  = tim_c_q[RECALL_LO +: RECALL_W];
        tim_o.setup   = tim_c_q[SETUP_LO +: SETUP_W];
    end

    assign cmd_o        = cmd_q;
    assign flash_addr_o = addr_q;

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_AW'(OFS_CTRL):  rdata_o[CMD_LO +: CMD_N] = cmd_q;
            REG_AW'(OFS_TIM_A): rdata_o = tim_a_q;
            REG_AW'(OFS_TIM_B): rdata_o = tim_b_q;
            REG_AW'(OFS_TIM_C): rdata_o = tim_c_q;
            REG_AW'(OFS_ADDR):  rdata_o[ADDR_W-1:0] = addr_q;
            REG_AW'(OFS_STAT):  rdata_o[0] = busy_i;
            default:            rdata_o = '0;
        endcase
    end

    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cmd_q == '0));                                          // R4
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_i) |=> ($stable(tim_a_q) && $stable(tim_b_q)
                              && $stable(tim_c_q) && $stable(addr_q)));      // R9

endmodule

// File: rtl/fos_cmd_pick.sv
module fos_cmd_pick
    import fos_pkg::*;
#(
    parameter int N = CMD_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cmd_i,
    output logic         valid_o,
    output op_e          op_o
);

    logic [N-1:0] grant;

    // lowest-numbered request wins
    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant[i] = cmd_i[i];
        end else begin : g_rest
            assign grant[i] = cmd_i[i] && !(|cmd_i[i-1:0]);
        end
    end

    assign valid_o = |cmd_i;

    always_comb begin
        op_o = OP_NONE;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) op_o = op_e'(k + 1);
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (valid_o == (grant != '0)));                      // R3

endmodule

// File: rtl/fos_phase_cnt.sv
module fos_phase_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            // a length of zero behaves as one cycle
            cnt_q <= (len_i == '0) ? '0 : len_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last_o = (cnt_q == '0);

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));                         // R8

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import fos_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int REG_AW     = 6,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy_o,
    output logic              done_o,
    output logic              fl_active,
    output logic              fl_pulse,
    output logic [2:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [5:0]        rd_wait
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

    state_e            state_q, state_d;
    op_e               op_q, pick_op;
    logic              pick_valid;
    logic [CMD_N-1:0]  cmd;
    timing_t           tim;
    logic [ADDR_W-1:0] addr_reg;
    logic              start, last, load, done_q;
    logic [CNT_W-1:0]  len;

    fos_regfile #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr),
        .addr_i       (reg_addr),
        .wdata_i      (reg_wdata),
        .busy_i       (busy_o),
        .start_i      (start),
        .cmd_o        (cmd),
        .tim_o        (tim),
        .flash_addr_o (addr_reg),
        .rdata_o      (reg_rdata)
    );

    fos_cmd_pick #(.N(CMD_N)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .valid_o (pick_valid),
        .op_o    (pick_op)
    );

    fos_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .len_i  (len),
        .last_o (last)
    );

    assign start = (state_q == ST_IDLE) && pick_valid;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_valid) state_d = ST_SETUP;   // start
            ST_SETUP: if (last)       state_d = ST_MAIN;    // setup_end
            ST_MAIN:  if (last)       state_d = ST_HOLD;    // main_end
            ST_HOLD:  if (last)       state_d = ST_IDLE;    // hold_end
            default:                  state_d = ST_IDLE;
        endcase
    end

    // phase length for the counter load on each transition
    always_comb begin
        len  = '0;
        load = (state_d != state_q) && (state_d != ST_IDLE);
        unique case (state_q)
            ST_IDLE: len = CNT_W'(tim.setup);
            ST_SETUP: begin
                unique case (op_q)
                    OP_PROG:   len = CNT_W'(tim.prog);
                    OP_RECALL: len = CNT_W'(tim.recall);
                    default:   len = tim.erase;
                endcase
            end
            ST_MAIN: len = CNT_W'(tim.hold);
            default: len = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) op_q <= pick_op;
            done_q  <= (state_q == ST_HOLD) && last;
        end
    end

    // outputs
    always_comb begin
        fl_active = (state_q != ST_IDLE);
        fl_pulse  = (state_q == ST_MAIN);
        fl_op     = fl_active ? op_q : OP_NONE;
        fl_addr   = '0;
        if (fl_active) begin
            unique case (op_q)
                OP_PAGE: fl_addr = addr_reg & ~PAGE_MASK;
                OP_PROG: fl_addr = addr_reg;
                default: fl_addr = '0;
            endcase
        end
    end

    assign busy_o  = fl_active || (cmd != '0);
    assign done_o  = done_q;
    assign rd_wait = tim.wait_st;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                                 // R11
    AST_OP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_active && $past(fl_active)) |-> $stable(fl_op));                 // R2
    AST_SETUP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |=> (state_q == ST_SETUP || state_q == ST_MAIN)); // R6
    AST_HOLD_AFTER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_pulse) |-> (fl_active && state_q == ST_HOLD));              // R6

endmodule

// File: tb/flash_op_sequencer_tb.sv
module flash_op_sequencer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy_o, done_o, fl_active, fl_pulse;
    logic [2:0]  fl_op;
    logic [19:0] fl_addr;
    logic [5:0]  rd_wait;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_o(busy_o),
        .done_o(done_o), .fl_active(fl_active), .fl_pulse(fl_pulse),
        .fl_op(fl_op), .fl_addr(fl_addr), .rd_wait(rd_wait)
    );

    typedef struct packed {
        logic [7:0]  cmd;
        logic [3:0]  su;
        logic [23:0] er;
        logic [15:0] pg;
        logic [7:0]  rc;
        logic [15:0] hd;
        logic [19:0] ad;
        logic [2:0]  e_op;
        logic [7:0]  e_main;
        logic [7:0]  e_busy;
        logic [19:0] e_addr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'h08, 4'd2, 24'd5, 16'd7,  8'd3, 16'd4, 20'h12345, 3'd1, 8'd5, 8'd12, 20'h00000},
        '{8'h10, 4'd1, 24'd6, 16'd7,  8'd3, 16'd2, 20'h12345, 3'd2, 8'd6, 8'd10, 20'h12000},
        '{8'h20, 4'd3, 24'd5, 16'd9,  8'd3, 16'd1, 20'h0ABCD, 3'd3, 8'd9, 8'd14, 20'h0ABCD},
        '{8'h40, 4'd0, 24'd0, 16'd7,  8'd3, 16'd0, 20'h55555, 3'd4, 8'd1, 8'd4,  20'h00000},
        '{8'h80, 4'd2, 24'd5, 16'd7,  8'd7, 16'd3, 20'h12345, 3'd5, 8'd7, 8'd13, 20'h00000},
        '{8'hF0, 4'd1, 24'd3, 16'd7,  8'd3, 16'd1, 20'hFFFFF, 3'd2, 8'd3, 8'd6,  20'hFF000},
        '{8'h28, 4'd1, 24'd4, 16'd11, 8'd3, 16'd2, 20'h12345, 3'd1, 8'd4, 8'd8,  20'h00000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic load_timing(input vec_t v);
        wr(6'h04, {v.hd, 16'h002A});
        wr(6'h08, {8'h00, v.er});
        wr(6'h0C, {4'h0, v.su, v.rc, v.pg});
        wr(6'h10, {12'h000, v.ad});
    endtask

    // runs from the negedge after the control write; counts busy/pulse cycles
    task automatic run_op(input vec_t v, input string tag);
        int nb = 0, np = 0;
        logic [2:0]  seen_op = '0;
        logic [19:0] seen_ad = '0;
        logic [31:0] r;
        reg_addr = 6'h00;
        while (busy_o && nb < 1000) begin
            nb++;
            if (fl_pulse) begin np++; seen_op = fl_op; seen_ad = fl_addr; end
            if (nb == 2) begin rd(6'h00, r); check({tag, " R4 cmd self-clear"}, r, 0); end
            @(negedge clk);
        end
        check({tag, " R5 busy length"}, nb, {24'd0, v.e_busy});
        check({tag, " R6/R7/R8 pulse length"}, np, {24'd0, v.e_main});
        check({tag, " R2/R3 op code"}, {29'd0, seen_op}, {29'd0, v.e_op});
        check({tag, " R10 address"}, {12'd0, seen_ad}, {12'd0, v.e_addr});
        check({tag, " R11 done high"}, {31'd0, done_o}, 1);
        @(negedge clk);
        check({tag, " R11 done one cycle"}, {31'd0, done_o}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(6'(a * 4), r);
            check("R1 register reset", r, 0);
        end
        check("R1 idle outputs", {26'd0, busy_o, done_o, fl_active, fl_pulse, fl_op},
              0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            load_timing(VEC[i]);
            check("R12 wait states", {26'd0, rd_wait}, 32'h2A);
            wr(6'h00, {24'd0, VEC[i].cmd});
            run_op(VEC[i], $sformatf("vec%0d", i));
        end

        // R9: writes during busy are ignored
        load_timing(VEC[0]);
        wr(6'h00, 32'h08);
        rd(6'h14, r);
        check("R5 status busy bit", r, 1);
        wr(6'h08, 32'h99);
        wr(6'h00, 32'h20);
        while (busy_o) @(negedge clk);
        rd(6'h08, r);
        check("R9 timing write ignored", r, 5);
        repeat (6) begin
            @(negedge clk);
            check("R9 no second operation", {31'd0, busy_o}, 0);
        end
        rd(6'h00, r);
        check("R9 command not latched", r, 0);
        rd(6'h14, r);
        check("R5 status idle", r, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule